// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Dispatcher

The dispatcher sits between two issue slots and the register-access stages of three execution back ends. Each cycle it looks at the decoded class of the instruction in slot 0 and slot 1. It chooses a dispatch stage for each one, or holds it. There are three dispatch stages. The first feeds the complex integer pipe. The second is shared by the simple integer pipe and the load/store pipe. The third feeds the floating-point pipe. Each dispatch stage takes at most one instruction per cycle.

Two timers hold back-end resources across cycles. A word divide keeps the complex pipe's write-back stage busy for a long stretch, and no complex-pipe dispatch is allowed during that time. A reservation instruction (load-reserve or store-conditional) claims the shared stage and the complex stage together, and it may only leave from slot 0. While one is still in the load/store back end, no second one may follow. Each slot gets an accept pulse in the cycle its instruction leaves. A slot that is not accepted keeps its instruction and tries again.

Top module: `dual_issue_steer`

## Requirements
- R1: While `rst` is high, neither slot is accepted and both routes read 0, whatever the inputs.
- R2: Class 0 (simple ALU: general, compare, rotate, shift) takes the shared stage (route 2) when that stage is still free this cycle. Otherwise it takes the complex stage (route 1) when that is free. Otherwise it stalls.
- R3: Classes 1, 6 and 7 (multiply, trap, branch, special-register moves) and class 2 (word divide) are dispatched only as route 1.
- R4: Class 3 (load, store, cache management) is dispatched as route 2's shared stage with route code 3. The shared stage is used by at most one slot per cycle.
- R5: Class 4 (reservation) is dispatched as route 5 only from slot 0, and only when the shared and the complex stage are both free. Slot 1 never dispatches class 4.
- R6: If a divide is accepted in cycle t, no instruction is routed to the complex stage (route 1 or 5) in cycles t+1 to t+DIV_HOLD (33). Route 1 is possible again from cycle t+DIV_HOLD+1.
- R7: If a reservation instruction is accepted in cycle t, no class 4 instruction is accepted in cycles t+1 to t+RESV_HOLD (3).
- R8: Class 5 (floating point) is dispatched only as route 4, and at most one per cycle.
- R9: Slot 1 is accepted only in a cycle where slot 0 is invalid or slot 0 is also accepted.
- R10: An accept is high only for a valid slot. A slot's route reads 0 whenever its accept is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot0_valid | input | 1 | Slot 0 holds an instruction |
| slot0_class | input | 3 | Slot 0 class code (0 ALU, 1/6/7 complex-only, 2 divide, 3 memory, 4 reservation, 5 FP) |
| slot1_valid | input | 1 | Slot 1 holds an instruction |
| slot1_class | input | 3 | Slot 1 class code, same encoding |
| slot0_accept | output | 1 | Slot 0 instruction dispatched this cycle |
| slot0_route | output | 3 | Slot 0 destination: 0 none, 1 complex, 2 simple, 3 load/store, 4 FP, 5 complex+load/store pair |
| slot1_accept | output | 1 | Slot 1 instruction dispatched this cycle |
| slot1_route | output | 3 | Slot 1 destination, same encoding |

## Verification
The assertions assume that the slot inputs are stable between clock edges. Every 3-bit class value is legal, because the codes 6 and 7 decode as complex-only. The assertions also assume that the issue side keeps a refused instruction in its slot, since the hold-window properties only make sense for instructions that retry. The random stimulus follows this rule: a slot gets a new instruction only after its current one has been accepted. Directed sequences cover a divide followed by back-to-back complex requests, repeated reservation attempts, and both slots competing for the shared or FP stage.

// File: rtl/dis_pkg.sv
package dis_pkg;

    typedef enum logic [2:0] {
        CL_ALU    = 3'd0,
        CL_CPLX   = 3'd1,
        CL_DIV    = 3'd2,
        CL_MEM    = 3'd3,
        CL_RESV   = 3'd4,
        CL_FP     = 3'd5,
        CL_CPLX_B = 3'd6,
        CL_CPLX_C = 3'd7
    } cls_e;

    typedef enum logic [2:0] {
        RT_NONE   = 3'd0,
        RT_CPLX   = 3'd1,
        RT_SIMPLE = 3'd2,
        RT_LDST   = 3'd3,
        RT_FP     = 3'd4,
        RT_PAIR   = 3'd5
    } route_e;

    // Dispatch resources still open in the current cycle
    typedef struct packed {
        logic cplx;
        logic shared;
        logic fp;
        logic resv;
    } free_t;

    localparam int DEF_DIV_HOLD  = 33;
    localparam int DEF_RESV_HOLD = 3;

    function automatic logic takes_shared(route_e r);
        return (r == RT_SIMPLE) || (r == RT_LDST) || (r == RT_PAIR);
    endfunction

    function automatic logic takes_cplx(route_e r);
        return (r == RT_CPLX) || (r == RT_PAIR);
    endfunction

endpackage

// File: rtl/dis_hold_timer.sv
module dis_hold_timer
    import dis_pkg::*;
#(
    parameter int HOLD = DEF_DIV_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= CW'(HOLD);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // Shared by the divide window (R6) and the reservation window (R7)
    assert_hold_load_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

endmodule

// File: rtl/dis_slot_steer.sv
module dis_slot_steer
    import dis_pkg::*;
#(
    parameter bit FIRST_SLOT = 1'b0
) (
    input  logic   valid,
    input  cls_e   cls,
    input  logic   order_in,
    input  free_t  free_in,
    output logic   accept,
    output route_e route,
    output free_t  free_out,
    output logic   order_out
);
    route_e cand;

    always_comb begin
        cand = RT_NONE;
        case (cls)
            CL_ALU: begin
                if (free_in.shared)    cand = RT_SIMPLE;
                else if (free_in.cplx) cand = RT_CPLX;
            end
            CL_MEM: begin
                if (free_in.shared) cand = RT_LDST;
            end
            CL_RESV: begin
                if (FIRST_SLOT && free_in.shared && free_in.cplx && free_in.resv)
                    cand = RT_PAIR;
            end
            CL_FP: begin
                if (free_in.fp) cand = RT_FP;
            end
            default: begin
                if (free_in.cplx) cand = RT_CPLX;
            end
        endcase
    end

    assign accept    = valid && order_in && (cand != RT_NONE);
    assign route     = accept ? cand : RT_NONE;
    assign order_out = order_in && (!valid || accept);

    always_comb begin
        free_out = free_in;
        if (accept) begin
            if (takes_shared(cand)) free_out.shared = 1'b0;
            if (takes_cplx(cand))   free_out.cplx   = 1'b0;
            if (cand == RT_FP)      free_out.fp     = 1'b0;
            if (cand == RT_PAIR)    free_out.resv   = 1'b0;
        end
    end

endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
    import dis_pkg::*;
#(
    parameter int DIV_HOLD  = DEF_DIV_HOLD,
    parameter int RESV_HOLD = DEF_RESV_HOLD
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot0_valid,
    input  logic [2:0] slot0_class,
    input  logic       slot1_valid,
    input  logic [2:0] slot1_class,
    output logic       slot0_accept,
    output logic [2:0] slot0_route,
    output logic       slot1_accept,
    output logic [2:0] slot1_route
);
    localparam int NSLOT = 2;

    logic   vld   [NSLOT];
    cls_e   cls   [NSLOT];
    logic   acc   [NSLOT];
    route_e rte   [NSLOT];
    free_t  avail [NSLOT+1];
    logic   ord   [NSLOT+1];

    logic div_busy, resv_busy, div_start, resv_start;

    assign vld[0] = slot0_valid;
    assign vld[1] = slot1_valid;
    assign cls[0] = cls_e'(slot0_class);
    assign cls[1] = cls_e'(slot1_class);

    assign ord[0]   = !rst;
    assign avail[0] = '{cplx: !div_busy, shared: 1'b1, fp: 1'b1, resv: !resv_busy};

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        dis_slot_steer #(.FIRST_SLOT(s == 0)) u_steer (
            .valid     (vld[s]),
            .cls       (cls[s]),
            .order_in  (ord[s]),
            .free_in   (avail[s]),
            .accept    (acc[s]),
            .route     (rte[s]),
            .free_out  (avail[s+1]),
            .order_out (ord[s+1])
        );
    end

    assign div_start  = (acc[0] && cls[0] == CL_DIV) || (acc[1] && cls[1] == CL_DIV);
    assign resv_start = acc[0] && cls[0] == CL_RESV;

    dis_hold_timer #(.HOLD(DIV_HOLD)) u_div_wb (
        .clk(clk), .rst(rst), .start(div_start), .busy(div_busy)
    );

    dis_hold_timer #(.HOLD(RESV_HOLD)) u_resv (
        .clk(clk), .rst(rst), .start(resv_start), .busy(resv_busy)
    );

    assign slot0_accept = acc[0];
    assign slot1_accept = acc[1];
    assign slot0_route  = rte[0];
    assign slot1_route  = rte[1];

    assert_resv_slot0_R5: assert property (@(posedge clk) disable iff (rst)
        !(slot1_accept && slot1_class == 3'd4));

    assert_div_block_R6: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> (slot0_route != 3'd1 && slot0_route != 3'd5 && slot1_route != 3'd1));

    assert_shared_once_R4: assert property (@(posedge clk) disable iff (rst)
        !((slot0_route == 3'd2 || slot0_route == 3'd3 || slot0_route == 3'd5) &&
          (slot1_route == 3'd2 || slot1_route == 3'd3)));

    assert_in_order_R9: assert property (@(posedge clk) disable iff (rst)
        slot1_accept |-> (!slot0_valid || slot0_accept));

    assert_fp_once_R8: assert property (@(posedge clk) disable iff (rst)
        !(slot0_route == 3'd4 && slot1_route == 3'd4));

    assert_resv_window_R7: assert property (@(posedge clk) disable iff (rst)
        resv_busy |-> slot0_route != 3'd5);

endmodule

// File: tb/dual_issue_steer_tb.sv
module dual_issue_steer_tb;
    localparam int DIVH  = 33;
    localparam int RESVH = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       v0, v1;
    logic [2:0] c0, c1;
    logic       a0, a1;
    logic [2:0] r0, r1;

    int n_chk  = 0;
    int n_fail = 0;
    int dcnt   = 0;
    int rcnt   = 0;
    bit done   = 1'b0;
    bit last_a0, last_a1;

    always #4 clk = ~clk;

    dual_issue_steer u_dut (
        .clk(clk), .rst(rst),
        .slot0_valid(v0), .slot0_class(c0),
        .slot1_valid(v1), .slot1_class(c1),
        .slot0_accept(a0), .slot0_route(r0),
        .slot1_accept(a1), .slot1_route(r1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R2";
            3'd2: return "R6";
            3'd3: return "R4";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R3";
        endcase
    endfunction

    // Expected route for one slot from the written rules; consumes resources
    function automatic int pick(input bit v, input bit ordok, input bit first,
                                input logic [2:0] c, inout bit cx, inout bit sh,
                                inout bit fp, input bit rv);
        int r = 0;
        if (!v || !ordok) return 0;
        case (c)
            3'd0: if (sh) begin r = 2; sh = 0; end
                  else if (cx) begin r = 1; cx = 0; end
            3'd3: if (sh) begin r = 3; sh = 0; end
            3'd4: if (first && sh && cx && rv) begin r = 5; sh = 0; cx = 0; end
            3'd5: if (fp) begin r = 4; fp = 0; end
            default: if (cx) begin r = 1; cx = 0; end
        endcase
        return r;
    endfunction

    task automatic step(input bit rr, input bit iv0, input logic [2:0] ic0,
                        input bit iv1, input logic [2:0] ic1, input string tag);
        bit cx, sh, fp, ord1;
        int e0, e1;
        @(negedge clk);
        rst = rr; v0 = iv0; c0 = ic0; v1 = iv1; c1 = ic1;
        #3;
        cx = (dcnt == 0); sh = 1; fp = 1;
        e0 = rr ? 0 : pick(iv0, 1'b1, 1'b1, ic0, cx, sh, fp, rcnt == 0);
        ord1 = !rr && (!iv0 || e0 != 0);
        e1 = pick(iv1, ord1, 1'b0, ic1, cx, sh, fp, rcnt == 0);
        check(a0 == (e0 != 0), tag, a0, e0 != 0);
        check(r0 == e0[2:0], tag, r0, e0);
        check(a1 == (e1 != 0), tag, a1, e1 != 0);
        check(r1 == e1[2:0], tag, r1, e1);
        check((a0 || r0 == 0) && (a1 || r1 == 0) && (!a0 || iv0) && (!a1 || iv1),
              "R10", {a0, a1}, 0);
        last_a0 = a0; last_a1 = a1;
        @(posedge clk);
        if (rr) begin dcnt = 0; rcnt = 0; end
        else begin
            if ((e0 != 0 && ic0 == 3'd2) || (e1 != 0 && ic1 == 3'd2)) dcnt = DIVH;
            else if (dcnt > 0) dcnt--;
            if (e0 == 5) rcnt = RESVH;
            else if (rcnt > 0) rcnt--;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int stalls;
        bit sv0, sv1;
        logic [2:0] sc0, sc1;
        rst = 1'b1; v0 = 0; v1 = 0; c0 = 0; c1 = 0;
        void'($urandom(32'h5eed_1234));
        // R1: reset holds everything off
        step(1, 1, 3'd0, 1, 3'd5, "R1");
        step(1, 1, 3'd2, 1, 3'd3, "R1");
        // R2: two ALU ops split simple/complex; MEM pushes ALU to complex
        step(0, 1, 3'd0, 1, 3'd0, "R2");
        step(0, 1, 3'd3, 1, 3'd0, "R2");
        // R3: complex-only classes
        step(0, 1, 3'd1, 1, 3'd6, "R3");
        step(0, 1, 3'd0, 1, 3'd7, "R3");
        // R4 / R8: contention on shared and FP stages
        step(0, 1, 3'd3, 1, 3'd3, "R4");
        step(0, 1, 3'd5, 1, 3'd5, "R8");
        // R5: reservation from slot 1 never leaves
        step(0, 0, 3'd0, 1, 3'd4, "R5");
        step(0, 1, 3'd5, 1, 3'd4, "R5");
        // R7: reservation then retries during the hold window
        step(0, 1, 3'd4, 0, 3'd0, "R7");
        for (int i = 0; i < RESVH + 1; i++) step(0, 1, 3'd4, 0, 3'd0, "R7");
        // R6: divide then count complex stalls
        step(0, 1, 3'd2, 0, 3'd0, "R6");
        stalls = 0;
        for (int i = 0; i < 60; i++) begin
            step(0, 1, 3'd1, 1, 3'd5, "R9");
            if (last_a0) break;
            check(!last_a1, "R9", last_a1, 0);
            stalls++;
        end
        check(stalls == DIVH, "R6", stalls, DIVH);
        // R2: ALU in slot 1 with shared taken and complex busy stalls
        step(0, 1, 3'd2, 0, 3'd0, "R6");
        step(0, 1, 3'd3, 1, 3'd0, "R2");
        step(1, 0, 3'd0, 0, 3'd0, "R1");
        // Random traffic; a refused slot keeps its instruction
        sv0 = 0; sv1 = 0; sc0 = 0; sc1 = 0;
        for (int i = 0; i < 4000; i++) begin
            if (!sv0 || last_a0) begin sv0 = ($urandom % 4) != 0; sc0 = 3'($urandom % 8); end
            if (!sv1 || last_a1) begin sv1 = ($urandom % 4) != 0; sc1 = 3'($urandom % 8); end
            step(($urandom % 500) == 0, sv0, sc0, sv1, sc1, req_of(sc0));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule